// File: doc/BRIEF.md
# Analog Input Conversion Controller

This block sits between a register bus and a multiplexed analog-to-digital converter that has ten inputs: eight differential signals, a +10 V reference and a 0 V reference. The input range is bipolar ±10 V.

Software writes a single control word. The word carries one enable bit per input, the number of the input to convert, a flag that asks for a settling pause, and a start bit. The block then steers the converter's input selector. If the pause was asked for, it waits a parameterised number of cycles. It then pulses the converter start and waits for the converter's done strobe.

On completion, the block stores the sample with its top bit inverted, which turns the converter's offset-binary code into two's complement. It also raises a sticky completion flag. Software clears that flag by writing 1 to it. An enable bit routes the flag onto an interrupt line.

Top module: `adc_conv_ctl`

## Requirements
- R1: After reset, every register reads zero, and `irq` and `conv_start` are low.
- R2: The control word is at address 0. Its fields are: bit 0 start, bits 4:1 input number, bits 14:5 one enable bit per input (bit 5+n enables input n), and bit 15 the settling request. A read returns bits 15:1 as last accepted. Bit 0 reads 1 while a conversion is in progress and 0 otherwise, so the start bit clears itself.
- R3: A start that names an enabled input, with bit 15 clear, drives `conv_chan` to that input. It raises `conv_start` for exactly one cycle, in the cycle that follows the write edge.
- R4: With bit 15 set, `conv_start` rises SETTLE_CYC cycles later than it would without the settling request. `conv_chan` already shows the input during the pause.
- R5: A start is ignored if it names an input whose enable bit is clear, or a number of 10 or above. No `conv_start` follows, and the completion flag stays clear.
- R6: A control write that arrives while a conversion is in progress is ignored. It starts no second conversion, and the stored control word does not change.
- R7: When `conv_done` arrives during a conversion, address 3 returns `conv_data` with bit 15 inverted, and bit 2 of the status register (address 1) becomes 1.
- R8: Writing 1 to status bit 2 clears the completion flag. Writing 0 to bit 2 leaves the flag unchanged, whatever the other bits hold.
- R9: Bit 2 of the interrupt-enable register (address 2) gates the flag: `irq` equals flag AND enable. `irq` stays high until software clears the flag or the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| irq | output | 1 | Conversion-complete interrupt |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 4 | Input selector to the converter multiplexer |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 16 | Converter sample, offset binary |

## Verification
The embedded properties assume two things about the converter. First, it raises `conv_done` only after a start pulse, never unprompted. Second, it presents valid `conv_data` in the same cycle as `conv_done`. The bench's converter model respects both. It arms only on a sampled `conv_start`, and it answers after a fixed latency with data it records for the checks. The properties also assume that register writes are single-cycle strobes. The bench's write task always releases `wr_en` one cycle after raising it.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
   localparam int REG_W    = 16;
   localparam int SEL_W    = 4;
   localparam int MAX_CH   = 10;
   localparam int EN_LSB   = 5;
   localparam int DLY_BIT  = 15;
   localparam int FLAG_BIT = 2;

   localparam logic [1:0] A_CTRL   = 2'd0;
   localparam logic [1:0] A_STATUS = 2'd1;
   localparam logic [1:0] A_IRQEN  = 2'd2;
   localparam logic [1:0] A_RESULT = 2'd3;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_SETTLE = 2'd1,
      SQ_FIRE   = 2'd2,
      SQ_WAIT   = 2'd3
   } seq_state_t;
endpackage

// File: rtl/adc_ctl_fmt.sv
module adc_ctl_fmt #(
   parameter int W    = 16,
   parameter bit TWOS = 1'b1
) (
   input  logic [W-1:0] raw,
   output logic [W-1:0] fmt
);
   if (W < 2) begin : g_bad_w
      $error("adc_ctl_fmt: W must be at least 2");
   end

   if (TWOS) begin : g_twos
      assign fmt = {~raw[W-1], raw[W-2:0]};
   end else begin : g_raw
      assign fmt = raw;
   end
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
   import adc_ctl_pkg::*;
#(
   parameter int NUM_CH     = 10,
   parameter int SETTLE_CYC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [SEL_W-1:0] sel_i,
   input  logic [NUM_CH-1:0] en_i,
   input  logic             dly_i,
   input  logic             conv_done,
   output logic             busy,
   output logic             conv_start,
   output logic [SEL_W-1:0] conv_chan,
   output logic             cmplt
);
   localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

   seq_state_t       st_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sel_ok;
   logic             go_settle;
   logic             cnt_zero;

   always_comb begin
      sel_ok = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (sel_i == SEL_W'(i) && en_i[i]) sel_ok = 1'b1;
      end
   end

   if (SETTLE_CYC == 0) begin : g_no_settle
      assign go_settle = 1'b0;
      assign cnt_zero  = 1'b1;
      always_ff @(posedge clk) cnt_q <= '0;
   end else begin : g_settle
      assign go_settle = dly_i;
      assign cnt_zero  = (cnt_q == '0);
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (launch && sel_ok && st_q == SQ_IDLE)
            cnt_q <= CNT_W'(SETTLE_CYC - 1);
         else if (st_q == SQ_SETTLE && !cnt_zero)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         sel_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: if (launch && sel_ok) begin
               sel_q <= sel_i;
               st_q  <= go_settle ? SQ_SETTLE : SQ_FIRE;
            end
            SQ_SETTLE: if (cnt_zero) st_q <= SQ_FIRE;
            SQ_FIRE:   st_q <= SQ_WAIT;
            SQ_WAIT:   if (conv_done) st_q <= SQ_IDLE;
            default:   st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy       = (st_q != SQ_IDLE);
   assign conv_start = (st_q == SQ_FIRE);
   assign conv_chan  = sel_q;
   assign cmplt      = (st_q == SQ_WAIT) && conv_done;

   // R3: start is a single-cycle pulse
   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   // R5: a start pulse only ever addresses an input below the channel count
   assert_start_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> (conv_chan < SEL_W'(NUM_CH)));
   // R6: selector holds for the whole conversion
   assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(conv_chan));
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
   import adc_ctl_pkg::*;
#(
   parameter int NUM_CH = 10,
   parameter bit TWOS   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [REG_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [REG_W-1:0] rd_data,
   input  logic             busy,
   input  logic             cmplt,
   input  logic [REG_W-1:0] conv_data,
   output logic             launch,
   output logic             irq
);
   logic [REG_W-1:1] ctl_q;
   logic             flag_q;
   logic             ie_q;
   logic [REG_W-1:0] res_q;
   logic [REG_W-1:0] res_fmt;
   logic             ctl_wr;
   logic             clr_req;

   assign ctl_wr  = wr_en && (wr_addr == A_CTRL) && !busy;
   assign launch  = ctl_wr && wr_data[0];
   assign clr_req = wr_en && (wr_addr == A_STATUS) && wr_data[FLAG_BIT];

   adc_ctl_fmt #(.W(REG_W), .TWOS(TWOS)) u_fmt (
      .raw (conv_data),
      .fmt (res_fmt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         flag_q <= 1'b0;
         ie_q   <= 1'b0;
         res_q  <= '0;
      end else begin
         if (ctl_wr) ctl_q <= wr_data[REG_W-1:1];
         if (wr_en && wr_addr == A_IRQEN) ie_q <= wr_data[FLAG_BIT];
         if (cmplt) begin
            res_q  <= res_fmt;
            flag_q <= 1'b1;
         end else if (clr_req) begin
            flag_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL:   rd_data = {ctl_q, busy};
         A_STATUS: rd_data[FLAG_BIT] = flag_q;
         A_IRQEN:  rd_data[FLAG_BIT] = ie_q;
         default:  rd_data = res_q;
      endcase
   end

   assign irq = flag_q & ie_q;

   // R6: stored control word frozen while a conversion runs
   assert_ctl_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ctl_q));
   // R7: flag rises only from a completion
   assert_flag_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(cmplt));
   // R8: flag falls only on a write-1-to-clear
   assert_flag_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(clr_req));
   // R9: interrupt drops only on a clear or an enable change
   assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(clr_req || (wr_en && wr_addr == A_IRQEN)));
endmodule

// File: rtl/adc_conv_ctl.sv
module adc_conv_ctl
   import adc_ctl_pkg::*;
#(
   parameter int NUM_CH     = 10,
   parameter int SETTLE_CYC = 16,
   parameter bit TWOS       = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [15:0] wr_data,
   input  logic [1:0]  rd_addr,
   output logic [15:0] rd_data,
   output logic        irq,
   output logic        conv_start,
   output logic [3:0]  conv_chan,
   input  logic        conv_done,
   input  logic [15:0] conv_data
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("adc_conv_ctl: NUM_CH must be 1..10");
   end
   if (SETTLE_CYC < 0) begin : g_bad_settle
      $error("adc_conv_ctl: SETTLE_CYC must not be negative");
   end

   logic busy;
   logic cmplt;
   logic launch;

   adc_ctl_regs #(.NUM_CH(NUM_CH), .TWOS(TWOS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .busy      (busy),
      .cmplt     (cmplt),
      .conv_data (conv_data),
      .launch    (launch),
      .irq       (irq)
   );

   adc_ctl_seq #(.NUM_CH(NUM_CH), .SETTLE_CYC(SETTLE_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .sel_i      (wr_data[SEL_W:1]),
      .en_i       (wr_data[EN_LSB+NUM_CH-1:EN_LSB]),
      .dly_i      (wr_data[DLY_BIT]),
      .conv_done  (conv_done),
      .busy       (busy),
      .conv_start (conv_start),
      .conv_chan  (conv_chan),
      .cmplt      (cmplt)
   );

   // R5: no completion can occur outside a conversion
   assert_cmplt_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmplt |-> busy);
endmodule

// File: tb/sim_adc_conv_ctl.sv
module sim_adc_conv_ctl;
   localparam int SETTLE = 5;
   localparam int LAT    = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        irq, conv_start;
   logic [3:0]  conv_chan;
   logic        conv_done = 1'b0;
   logic [15:0] conv_data = '0;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int starts = 0;
   int stub_cnt = 0;
   int stub_seq = 0;
   logic [15:0] last_data = '0;

   always #5 clk = ~clk;

   adc_conv_ctl #(.NUM_CH(10), .SETTLE_CYC(SETTLE), .TWOS(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
      .conv_start(conv_start), .conv_chan(conv_chan),
      .conv_done(conv_done), .conv_data(conv_data));

   // converter model: fixed latency, data derived from input and sequence
   always @(posedge clk) begin
      cyc <= cyc + 1;
      conv_done <= 1'b0;
      if (conv_start) begin
         starts   <= starts + 1;
         stub_cnt <= LAT;
      end else if (stub_cnt != 0) begin
         stub_cnt <= stub_cnt - 1;
         if (stub_cnt == 1) begin
            conv_done <= 1'b1;
            conv_data <= 16'((conv_chan * 16'h1731) + (stub_seq * 16'h0457)) ^ 16'h5A00;
            last_data <= 16'((conv_chan * 16'h1731) + (stub_seq * 16'h0457)) ^ 16'h5A00;
            stub_seq  <= stub_seq + 1;
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic wait_idle();
      logic [15:0] v;
      for (int i = 0; i < 60; i++) begin
         rd(2'd0, v);
         if (!v[0]) break;
         @(negedge clk);
      end
   endtask

   initial begin
      logic [15:0] v;
      int n, s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk(v == 16'h0, "R1 reg", v, 0);
      end
      chk(!irq && !conv_start, "R1 outputs", {irq, conv_start}, 0);

      // R2/R3/R4/R7/R8 sweep every input, with and without settling
      for (int ch = 0; ch < 10; ch++) begin
         for (int dl = 0; dl < 2; dl++) begin
            logic [15:0] w;
            w = 16'(dl << 15) | 16'(10'h3FF << 5) | 16'(ch << 1) | 16'h1;
            s0 = starts;
            wr(2'd0, w);
            rd(2'd0, v);
            chk(v == w, "R2 readback busy", v, w);
            chk(conv_chan == 4'(ch), "R4 selector early", conv_chan, ch);
            n = 1;
            while (!conv_start && n < 50) begin @(negedge clk); n++; end
            chk(n == (dl ? SETTLE + 1 : 1), dl ? "R4 settle latency" : "R3 start latency", n, dl ? SETTLE + 1 : 1);
            chk(conv_chan == 4'(ch), "R3 selector", conv_chan, ch);
            @(negedge clk);
            chk(!conv_start, "R3 single pulse", conv_start, 0);
            wait_idle();
            chk(starts == s0 + 1, "R3 one start", starts - s0, 1);
            rd(2'd0, v);
            chk(v == (w & 16'hFFFE), "R2 start self-clears", v, w & 16'hFFFE);
            rd(2'd3, v);
            chk(v == (last_data ^ 16'h8000), "R7 result", v, last_data ^ 16'h8000);
            rd(2'd1, v);
            chk(v == 16'h0004, "R7 flag set", v, 4);
            wr(2'd1, 16'hFFFB);
            rd(2'd1, v);
            chk(v == 16'h0004, "R8 write 0 keeps flag", v, 4);
            wr(2'd1, 16'h0004);
            rd(2'd1, v);
            chk(v == 16'h0000, "R8 W1C", v, 0);
         end
      end

      // R5 disabled inputs and out-of-range numbers
      for (int ch = 0; ch < 16; ch++) begin
         logic [15:0] w;
         w = (ch < 10) ? (16'(10'h3FF << 5) & ~16'(1 << (ch + 5))) : 16'(10'h3FF << 5);
         w = w | 16'(ch << 1) | 16'h1;
         s0 = starts;
         wr(2'd0, w);
         repeat (SETTLE + LAT + 4) @(negedge clk);
         chk(starts == s0, "R5 no start", starts - s0, 0);
         rd(2'd1, v);
         chk(v == 16'h0, "R5 no flag", v, 0);
      end

      // R6 write while busy
      s0 = starts;
      wr(2'd0, 16'h8000 | 16'h0020 << 2 | 16'(2 << 1) | 16'h1);
      wr(2'd0, 16'h7FE0 | 16'(5 << 1) | 16'h1);
      rd(2'd0, v);
      chk(v == (16'h8081 | 16'h0004), "R6 word unchanged", v, 16'h8085);
      wait_idle();
      repeat (SETTLE + LAT + 4) @(negedge clk);
      chk(starts == s0 + 1, "R6 single conversion", starts - s0, 1);
      rd(2'd1, v);
      chk(v == 16'h4, "R6 flag from first", v, 4);
      wr(2'd1, 16'h4);

      // R9 interrupt gating and persistence
      wr(2'd2, 16'h0004);
      rd(2'd2, v);
      chk(v == 16'h4, "R9 enable readback", v, 4);
      chk(!irq, "R9 idle irq low", irq, 0);
      wr(2'd0, 16'h0400 | 16'(5 << 1) | 16'h1);
      wait_idle();
      chk(irq, "R9 irq on done", irq, 1);
      repeat (20) @(negedge clk);
      chk(irq, "R9 irq holds", irq, 1);
      wr(2'd1, 16'hFFFB);
      chk(irq, "R9 irq survives zero write", irq, 1);
      wr(2'd2, 16'h0000);
      chk(!irq, "R9 irq masked", irq, 0);
      wr(2'd2, 16'h0004);
      chk(irq, "R9 irq unmasked", irq, 1);
      wr(2'd1, 16'h0004);
      chk(!irq, "R9 irq cleared", irq, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule